// File: doc/BRIEF.md
# Pin-Bound Control Register

A single 32-bit control register whose bit fields are tied to wires outside the block. Some fields drive groups of output pins and others capture the levels of input pins. Each group of fields is set up at build time with five things: the register bit where it starts, whether it drives or captures, whether it is active low, how many instances it has, and how many bits each instance holds. Instance `i` of a group covers `width` bits starting at `base + i*width`. A count or a width of zero is treated as one.

Software writes the register through a plain write port. The port carries a per-bit enable mask, and the current value can always be read. After every write, and once when reset is released, each output instance compares its new polarity-adjusted value with the value its pins hold now. Only the instances whose value differs load their pins and raise a one-cycle change strobe. Captured fields cannot be written from the bus. Their pins pass through a two-flop synchroniser and are placed into their own field bits, and no other bit of the register is affected.

The default build has three output groups and two input groups. The output groups are: bits 0..7 as four 2-bit instances, active high; bits 8..13 as two 3-bit instances, active low; and bits 28..31 as one 4-bit instance, configured with count 0. The input groups are: bits 16..21 as three 2-bit instances, active high; and bit 24 as one 1-bit instance, configured with count 0 and width 0, active low. Bits 14, 15, 22, 23 and 25..27 are plain storage.

Top module: `ctrl_pinreg`

## Requirements
- R1: While `rst_n` is low, `rd_data` equals `RESET_VAL` (default 0x0000071B), `out_pins` is all zero and `out_stb` is all zero. In the cycle after the first clock edge with `rst_n` high, each output instance shows its polarity-adjusted reset field on its pins, and its strobe is high exactly when that value is non-zero.
- R2: Output instance `i` of a group is taken from register bits `base + i*width` upward. Its pins sit in `out_pins` in group order and then instance order, starting with group 0 at pin 0: bits 0..7 go to pins 0..7, bits 8..13 go to pins 8..13, and bits 28..31 go to pins 14..17. Strobes follow the same order: indices 0..3, then 4..5, then 6.
- R3: A group configured with a zero count or a zero width acts as one instance or as one bit per instance. Bits 28..31 form a single 4-bit output with strobe 6, and bit 24 is a single 1-bit input taken from `in_pins[6]`.
- R4: An active-low group inverts every bit between the register and the pins, in both directions. This applies to the output bits 8..13 and to the input bit 24.
- R5: A write changes only the bits whose `wr_mask` bit is 1. A write with a zero mask changes no bit, no pin and no strobe.
- R6: A write raises a strobe only for the instances whose polarity-adjusted value changed. All other pins hold their value.
- R7: A strobe is high for exactly one cycle, the cycle after the write is sampled. It is low again in the cycle after that.
- R8: Writes to input field bits (16..21 and 24) have no effect. Reads return the captured pin value.
- R9: An input pin change appears in `rd_data` after the second clock edge following the change, and not after the first. Input pins are mapped in order: `in_pins[5:0]` go to bits 16..21 and `in_pins[6]` goes to bit 24.
- R10: An input deposit and a bus write in the same clock edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| rd_data | output | 32 | Current register value |
| in_pins | input | 7 | External levels captured into the input fields |
| out_pins | output | 18 | Registered levels of the output instances |
| out_stb | output | 7 | One-cycle change pulse, one bit per output instance |

## Verification
The bench targets the write whose value matches the current one. A design that strobes on every write fails this case by raising a strobe, and so does a design that compares raw bits against already-inverted pins. Partial masks that touch one instance of a multi-instance group catch an off-by-one in the `base + i*width` layout, because the strobe or pin of a neighbouring instance moves. An input change is sampled after exactly one edge and again after two, which exposes a synchroniser that is too short or too long. All-ones writes over the input bits show whether bus writes leak into captured fields. A write made in the same edge as a deposit catches a design that lets one of them overwrite the other.

// File: rtl/pinreg_pkg.sv
package pinreg_pkg;
  localparam int DATA_W = 32;
  localparam int NG     = 5;
  // group table: 1 = output group
  localparam int G_OUT  [NG] = '{1, 1, 0, 0, 1};
  localparam int G_BASE [NG] = '{0, 8, 16, 24, 28};
  localparam int G_CNT  [NG] = '{4, 2, 3, 0, 0};
  localparam int G_WID  [NG] = '{2, 3, 2, 0, 4};
  localparam int G_POL  [NG] = '{0, 1, 0, 1, 0};

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int span(int g);
    return eff(G_CNT[g]) * eff(G_WID[g]);
  endfunction

  // offset of group g among pins or strobes of the same direction
  function automatic int pin_off(int g, int want_out, int count_inst);
    int acc = 0;
    for (int h = 0; h < g; h++)
      if (G_OUT[h] == want_out) acc += (count_inst != 0) ? eff(G_CNT[h]) : span(h);
    return acc;
  endfunction

  function automatic logic [DATA_W-1:0] in_mask();
    logic [DATA_W-1:0] m = '0;
    for (int g = 0; g < NG; g++)
      if (G_OUT[g] == 0)
        for (int b = 0; b < DATA_W; b++)
          if (b >= G_BASE[g] && b < G_BASE[g] + span(g)) m[b] = 1'b1;
    return m;
  endfunction

  localparam int OUT_PINS = pin_off(NG, 1, 0);
  localparam int N_STB    = pin_off(NG, 1, 1);
  localparam int IN_PINS  = pin_off(NG, 0, 0);
  localparam logic [DATA_W-1:0] IN_MASK = in_mask();
endpackage

// File: rtl/pinreg_store.sv
module pinreg_store #(
  parameter int W = 32,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter logic [W-1:0] RO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] dep_val,
  output logic [W-1:0] reg_q,
  output logic [W-1:0] reg_nx
);
  logic [W-1:0] wmask;

  assign wmask = wr_en ? (wr_mask & ~RO_MASK) : '0;

  always_comb begin
    reg_nx = (reg_q & ~wmask) | (wr_data & wmask);
    reg_nx = (reg_nx & ~RO_MASK) | (dep_val & RO_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= RESET_VAL;
    else        reg_q <= reg_nx;
  end
endmodule

// File: rtl/pinreg_in_sync.sv
module pinreg_in_sync #(
  parameter int WID = 1,
  parameter bit POL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WID-1:0] pins,
  output logic [WID-1:0] adj
);
  logic [WID-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_q <= '0;
    else        meta_q <= pins;
  end

  // second stage is the register field itself
  assign adj = meta_q ^ {WID{POL}};
endmodule

// File: rtl/pinreg_out_group.sv
module pinreg_out_group #(
  parameter int CNT = 1,
  parameter int WID = 1,
  parameter bit POL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [CNT*WID-1:0] field_nx,
  output logic [CNT*WID-1:0] pins,
  output logic [CNT-1:0]     stb
);
  for (genvar i = 0; i < CNT; i++) begin : g_inst
    logic [WID-1:0] nv;
    logic           ch;
    assign nv = field_nx[i*WID +: WID] ^ {WID{POL}};
    assign ch = upd && (nv != pins[i*WID +: WID]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pins[i*WID +: WID] <= '0;
        stb[i]             <= 1'b0;
      end else begin
        stb[i] <= ch;
        if (ch) pins[i*WID +: WID] <= nv;
      end
    end
  end
endmodule

// File: rtl/ctrl_pinreg.sv
module ctrl_pinreg
  import pinreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_071B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W-1:0]   wr_mask,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [IN_PINS-1:0]  in_pins,
  output logic [OUT_PINS-1:0] out_pins,
  output logic [N_STB-1:0]    out_stb
);
  logic              pend_q;
  logic              upd_evt;
  logic [DATA_W-1:0] reg_q, reg_nx, dep_val;
  logic [DATA_W-1:0] dep_g [NG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  assign upd_evt = wr_en | pend_q;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int BASE = G_BASE[g];
    localparam int CNT  = eff(G_CNT[g]);
    localparam int WID  = eff(G_WID[g]);
    localparam int SPAN = CNT * WID;
    localparam bit POL  = (G_POL[g] != 0);
    if (G_OUT[g] != 0) begin : g_out
      localparam int PO = pin_off(g, 1, 0);
      localparam int SO = pin_off(g, 1, 1);
      pinreg_out_group #(.CNT(CNT), .WID(WID), .POL(POL)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd_evt),
        .field_nx(reg_nx[BASE +: SPAN]),
        .pins    (out_pins[PO +: SPAN]),
        .stb     (out_stb[SO +: CNT])
      );
      assign dep_g[g] = '0;
    end else begin : g_in
      localparam int PI = pin_off(g, 0, 0);
      logic [SPAN-1:0] adj;
      pinreg_in_sync #(.WID(SPAN), .POL(POL)) u_in (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (in_pins[PI +: SPAN]),
        .adj  (adj)
      );
      assign dep_g[g] = DATA_W'(adj) << BASE;
    end
  end

  always_comb begin
    dep_val = '0;
    for (int g = 0; g < NG; g++) dep_val = dep_val | dep_g[g];
  end

  pinreg_store #(.W(DATA_W), .RESET_VAL(RESET_VAL), .RO_MASK(IN_MASK)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .wr_mask(wr_mask),
    .dep_val(dep_val),
    .reg_q  (reg_q),
    .reg_nx (reg_nx)
  );

  assign rd_data = reg_q;
endmodule

// File: rtl/pinreg_chk.sv
module pinreg_chk
  import pinreg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                upd_evt,
  input logic [DATA_W-1:0]   rd_data,
  input logic [OUT_PINS-1:0] out_pins,
  input logic [N_STB-1:0]    out_stb
);
  // R6 R7: strobes appear only after an update event
  a_r7_stb_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb != '0) |-> $past(upd_evt));

  // R6: pins move only together with a strobe
  a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb == '0) |-> $stable(out_pins));

  // R6: a strobe means the pins really changed
  a_r6_stb_real_change: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb != '0) |-> (out_pins != $past(out_pins)));

  // R5: writable bits hold when no write was sampled
  a_r5_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(rd_data & ~IN_MASK));

  // R7: strobes never last two cycles without a second write
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_stb != '0) && !$past(wr_en, 1)) |=> (out_stb == '0) || $past(wr_en));
endmodule

bind ctrl_pinreg pinreg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .upd_evt (upd_evt),
  .rd_data (rd_data),
  .out_pins(out_pins),
  .out_stb (out_stb)
);

// File: tb/ctrl_pinreg_tb.sv
module ctrl_pinreg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_V = 32'h0000_071B;
  localparam logic [31:0] INM   = 32'h013F_0000;
  localparam int OB [3] = '{0, 8, 28};
  localparam int OC [3] = '{4, 2, 1};
  localparam int OW [3] = '{2, 3, 4};
  localparam int OP [3] = '{0, 1, 0};
  localparam int IB [2] = '{16, 24};
  localparam int IC [2] = '{3, 1};
  localparam int IW [2] = '{2, 1};
  localparam int IP [2] = '{0, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0, wr_mask = '0;
  logic [31:0] rd_data;
  logic [6:0]  in_pins = '0;
  logic [17:0] out_pins;
  logic [6:0]  out_stb;

  int checks = 0, fails = 0;
  logic [31:0] em;
  logic [6:0]  in_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_pinreg u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_data(rd_data), .in_pins(in_pins),
    .out_pins(out_pins), .out_stb(out_stb));

  function automatic logic [17:0] exp_pins(logic [31:0] r);
    logic [17:0] p = '0;
    int k = 0;
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < OC[g]; i++)
        for (int b = 0; b < OW[g]; b++) begin
          p[k] = r[OB[g] + i*OW[g] + b] ^ OP[g][0];
          k++;
        end
    return p;
  endfunction

  function automatic logic [6:0] exp_stb(logic [31:0] o, logic [31:0] n);
    logic [6:0] s = '0;
    int k = 0;
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < OC[g]; i++) begin
        for (int b = 0; b < OW[g]; b++)
          if ((o[OB[g] + i*OW[g] + b] ^ OP[g][0]) != (n[OB[g] + i*OW[g] + b] ^ OP[g][0]))
            s[k] = 1'b1;
        k++;
      end
    return s;
  endfunction

  function automatic logic [31:0] in_field(logic [6:0] v);
    logic [31:0] r = '0;
    int k = 0;
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < IC[g]; i++)
        for (int b = 0; b < IW[g]; b++) begin
          r[IB[g] + i*IW[g] + b] = v[k] ^ IP[g][0];
          k++;
        end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd();
    return (em & ~INM) | in_field(in_cur);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(string req, logic [31:0] d, logic [31:0] m);
    logic [31:0] old = em;
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    em = (em & ~m) | (d & m);
    tick();
    wr_en = 1'b0;
    chk({req, " rd"}, 64'(rd_data), 64'(exp_rd()));
    chk({req, " pins"}, 64'(out_pins), 64'(exp_pins(em)));
    chk({req, " stb"}, 64'(out_stb), 64'(exp_stb(old, em)));
    tick();
    chk("R7 stb drop", 64'(out_stb), 64'(0));
    chk("R6 pins hold", 64'(out_pins), 64'(exp_pins(em)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    em = RST_V; in_cur = '0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset rd", 64'(rd_data), 64'(RST_V));
    chk("R1 reset pins", 64'(out_pins), 64'(0));
    chk("R1 reset stb", 64'(out_stb), 64'(0));
    rst_n = 1'b1;
    tick();
    chk("R1 release pins", 64'(out_pins), 64'(exp_pins(RST_V)));
    chk("R1 release stb", 64'(out_stb), 64'(7'h27));
    tick();
    chk("R1 stb drop", 64'(out_stb), 64'(0));
    chk("R4 input active low", 64'(rd_data), 64'(exp_rd()));

    do_write("R2 one instance", 32'h0000_0030, 32'h0000_0030);
    do_write("R4 active low out", 32'h0000_2A00, 32'h0000_3F00);
    do_write("R3 wide single", 32'hF000_0000, 32'hF000_0000);
    do_write("R5 zero mask", 32'hFFFF_FFFF, 32'h0000_0000);
    do_write("R6 same value", em, 32'hFFFF_FFFF);
    do_write("R8 input ro", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_write("R5 partial", 32'h0000_0000, 32'h0F00_C0C3);

    // R9 two-edge latency
    in_pins = 7'h55;
    tick();
    chk("R9 after one edge", 64'(rd_data), 64'(exp_rd()));
    in_cur = 7'h55;
    tick();
    chk("R9 after two edges", 64'(rd_data), 64'(exp_rd()));

    // R10 deposit and write in the same edge
    in_pins = 7'h2A;
    tick();
    in_cur = 7'h2A;
    do_write("R10 write with deposit", 32'h5A5A_A5A5, 32'hFFFF_FFFF);

    for (int n = 0; n < 80; n++) begin
      if ($urandom % 4 == 0) begin
        in_pins = 7'($urandom);
        tick(); tick();
        in_cur = in_pins;
        chk("R9 random input", 64'(rd_data), 64'(exp_rd()));
      end else begin
        do_write("R6 random write", $urandom, $urandom);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule